// File: doc/BRIEF.md
# Dual-Channel Soft Mute Attenuator

This block is a per-channel gain stage in a stereo oversampled audio path. It sits at the four-times-rate point: after the de-emphasis stage and before the last interpolation stage. Each channel carries its own mute request. When a request rises, that channel's gain coefficient walks down from unity to zero in small steps. When the request falls, the gain walks back up. The two channels never affect each other's ramp.

The gain is a 10-bit unsigned code. Code 1023 means unity and code 0 means silence. A shared strobe divider lets the gain move one code every second sample strobe. A full ramp therefore takes 2046 four-times-rate samples, which is about 512 input-rate periods. Each channel output is the input multiplied by the gain and truncated back to 25 bits. Samples keep flowing through the block whatever the mute state.

The active-low reset overrides every mute request. It forces both outputs to zero at once, with no ramp. When reset is released, both channels start at unity gain.

Top module: `soft_mute_attenuator`

## Requirements
- R1: The left and right channels ramp independently. A mute request on one channel leaves the other channel's output equal to its own input times its own gain.
- R2: While a channel's mute request is high, its gain drops by exactly one code on each step strobe. A step strobe is every second sample strobe, counted from reset release. The gain stops at code 0.
- R3: While a channel's mute request is low, its gain rises by exactly one code on each step strobe. The gain stops at code 1023.
- R4: The gain starts at 1023, the divider starts at phase 0, and the mute request is held high from the first strobe after reset. Under these conditions, the channel's silent flag first rises after exactly 2046 sample strobes.
- R5: While rst_n is low, both sample outputs are 0, both silent flags are 1, and smp_vld_o is 0. The outputs clear immediately, without waiting for a clock edge.
- R6: After rst_n rises, both gains are 1023 whatever the mute requests are. The first strobed sample after reset passes through unchanged.
- R7: On a sample strobe, the matching output updates one clock later. With gain code g it becomes the input itself when g = 1023, and otherwise floor(input·g / 1024) as a 25-bit two's-complement value. The value uses the gain held before that strobe's step.
- R8: Reversing a mute request in the middle of a ramp turns the gain around from its current code. The gain never changes by more than one code per clock.
- R9: A channel's silent flag is 1 exactly when that channel's gain code is 0, and it is also 1 during reset.
- R10: A channel that is muted still accepts samples. smp_vld_o pulses one clock after every strobe, and the muted channel's output is 0.
- R11: Without a sample strobe, the outputs and gains hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; hard mute |
| smp_stb_i | input | 1 | Four-times-rate sample strobe |
| left_smp_i | input | 25 | Left sample, two's complement |
| right_smp_i | input | 25 | Right sample, two's complement |
| left_mute_req_i | input | 1 | Left mute request |
| right_mute_req_i | input | 1 | Right mute request |
| left_smp_o | output | 25 | Attenuated left sample |
| right_smp_o | output | 25 | Attenuated right sample |
| smp_vld_o | output | 1 | Output samples updated this cycle |
| left_silent_o | output | 1 | Left gain is zero |
| right_silent_o | output | 1 | Right gain is zero |

## Verification
The hardest situation to reach from the ports is a mute request reversed part-way through a ramp. The gain code itself is not visible, and random samples hide it. To expose it, the bench holds the input at positive full scale, so each output is a direct measure of the gain. It flips the request after a few hundred strobes and compares every output with an arithmetic model of the turn-around. Reset is also asserted asynchronously while a ramp is in progress. This shows that the outputs drop at once and that the next sample after release comes back at unity.

// File: rtl/soft_mute_pkg.sv
package soft_mute_pkg;
  localparam int DEF_SAMPLE_W = 25;
  localparam int DEF_GAIN_W   = 10;
  localparam int DEF_STEP_DIV = 2;
  localparam int NUM_CH       = 2;

  typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;
endpackage

// File: rtl/sm_step_divider.sv
module sm_step_divider #(
  parameter int STEP_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  output logic step_o
);
  localparam int CNT_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;

  generate
    if (STEP_DIV <= 1) begin : g_direct
      assign step_o = stb_i;
    end else begin : g_count
      localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_DIV - 1);
      logic [CNT_W-1:0] phase_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              phase_q <= '0;
        else if (stb_i) begin
          if (phase_q == LAST)   phase_q <= '0;
          else                   phase_q <= phase_q + 1'b1;
        end
      end

      assign step_o = stb_i && (phase_q == LAST);

      // R11: the phase only advances on a strobe
      p_phase_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(phase_q));
    end
  endgenerate
endmodule

// File: rtl/sm_gain_ramp.sv
module sm_gain_ramp #(
  parameter int GAIN_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              mute_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic              silent_o
);
  localparam logic [GAIN_W-1:0] GAIN_MAX = {GAIN_W{1'b1}};

  logic [GAIN_W-1:0] gain_q;
  logic              at_floor, at_ceil;

  function automatic logic [GAIN_W-1:0] next_gain(
    input logic [GAIN_W-1:0] g, input logic down);
    if (down) return (g == '0)      ? g : g - 1'b1;
    else      return (g == GAIN_MAX) ? g : g + 1'b1;
  endfunction

  assign at_floor = (gain_q == '0);
  assign at_ceil  = (gain_q == GAIN_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gain_q <= GAIN_MAX;
    else if (step_i) gain_q <= next_gain(gain_q, mute_i);
  end

  assign gain_o   = gain_q;
  assign silent_o = !rst_n || at_floor;

  p_ramp_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && mute_i && !at_floor |=> gain_q == $past(gain_q) - 1'b1);
  p_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && mute_i && at_floor |=> gain_q == '0);
  p_ramp_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !mute_i && !at_ceil |=> gain_q == $past(gain_q) + 1'b1);
  p_ceil_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !mute_i && at_ceil |=> gain_q == GAIN_MAX);
  p_single_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_q == $past(gain_q)) || (gain_q == $past(gain_q) + 1'b1) ||
    (gain_q == $past(gain_q) - 1'b1));
  p_gain_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(gain_q));
endmodule

// File: rtl/sm_gain_apply.sv
module sm_gain_apply #(
  parameter int SAMPLE_W = 25,
  parameter int GAIN_W   = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       stb_i,
  input  logic signed [SAMPLE_W-1:0] smp_i,
  input  logic        [GAIN_W-1:0]   gain_i,
  output logic signed [SAMPLE_W-1:0] smp_o
);
  localparam int PROD_W = SAMPLE_W + GAIN_W + 1;

  function automatic logic signed [SAMPLE_W-1:0] scale_sample(
    input logic signed [SAMPLE_W-1:0] s, input logic [GAIN_W-1:0] g);
    logic signed [PROD_W-1:0] prod;
    prod = PROD_W'(s) * $signed({1'b0, g});
    if (&g) return s;
    return prod[SAMPLE_W+GAIN_W-1:GAIN_W];
  endfunction

  logic signed [SAMPLE_W-1:0] scaled;
  logic                       gain_unity, gain_zero;

  assign scaled     = scale_sample(smp_i, gain_i);
  assign gain_unity = &gain_i;
  assign gain_zero  = (gain_i == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     smp_o <= '0;
    else if (stb_i) smp_o <= scaled;
  end

  p_unity_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stb_i && gain_unity |=> smp_o == $past(smp_i));
  p_zero_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stb_i && gain_zero |=> smp_o == '0);
  p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |=> $stable(smp_o));
endmodule

// File: rtl/soft_mute_attenuator.sv
module soft_mute_attenuator
  import soft_mute_pkg::*;
#(
  parameter int SAMPLE_W = DEF_SAMPLE_W,
  parameter int GAIN_W   = DEF_GAIN_W,
  parameter int STEP_DIV = DEF_STEP_DIV
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_stb_i,
  input  logic signed [SAMPLE_W-1:0] left_smp_i,
  input  logic signed [SAMPLE_W-1:0] right_smp_i,
  input  logic                       left_mute_req_i,
  input  logic                       right_mute_req_i,
  output logic signed [SAMPLE_W-1:0] left_smp_o,
  output logic signed [SAMPLE_W-1:0] right_smp_o,
  output logic                       smp_vld_o,
  output logic                       left_silent_o,
  output logic                       right_silent_o
);
  logic                       step;
  logic signed [SAMPLE_W-1:0] ch_in   [NUM_CH];
  logic signed [SAMPLE_W-1:0] ch_out  [NUM_CH];
  logic        [NUM_CH-1:0]   ch_mute;
  logic        [NUM_CH-1:0]   ch_silent;
  logic        [GAIN_W-1:0]   ch_gain [NUM_CH];

  assign ch_in[CH_LEFT]    = left_smp_i;
  assign ch_in[CH_RIGHT]   = right_smp_i;
  assign ch_mute[CH_LEFT]  = left_mute_req_i;
  assign ch_mute[CH_RIGHT] = right_mute_req_i;

  sm_step_divider #(.STEP_DIV(STEP_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .stb_i(smp_stb_i), .step_o(step));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sm_gain_ramp #(.GAIN_W(GAIN_W)) u_ramp (
      .clk(clk), .rst_n(rst_n), .step_i(step), .mute_i(ch_mute[c]),
      .gain_o(ch_gain[c]), .silent_o(ch_silent[c]));

    sm_gain_apply #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_apply (
      .clk(clk), .rst_n(rst_n), .stb_i(smp_stb_i), .smp_i(ch_in[c]),
      .gain_i(ch_gain[c]), .smp_o(ch_out[c]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_vld_o <= 1'b0;
    else        smp_vld_o <= smp_stb_i;
  end

  assign left_smp_o     = ch_out[CH_LEFT];
  assign right_smp_o    = ch_out[CH_RIGHT];
  assign left_silent_o  = ch_silent[CH_LEFT];
  assign right_silent_o = ch_silent[CH_RIGHT];

  p_reset_silence_r5: assert property (@(posedge clk)
    !rst_n |-> (left_smp_o == '0) && (right_smp_o == '0) &&
               left_silent_o && right_silent_o && !smp_vld_o);
  p_release_unity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !left_silent_o && !right_silent_o);
  p_silent_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    left_silent_o && $past(smp_stb_i) && $past(left_silent_o) |-> left_smp_o == '0);
endmodule

// File: tb/soft_mute_attenuator_test.sv
module soft_mute_attenuator_test;
  localparam int SW = 25;
  localparam int DIV = 2;
  localparam int GMAX = 1023;
  localparam logic signed [SW-1:0] POS_FS = 25'sh0FFFFFF;
  localparam logic signed [SW-1:0] NEG_FS = 25'sh1000000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic stb = 1'b0;
  logic signed [SW-1:0] in_l = '0, in_r = '0;
  logic mute_l = 1'b0, mute_r = 1'b0;
  logic signed [SW-1:0] out_l, out_r;
  logic vld, sil_l, sil_r;

  soft_mute_attenuator uut (
    .clk(clk), .rst_n(rst_n), .smp_stb_i(stb),
    .left_smp_i(in_l), .right_smp_i(in_r),
    .left_mute_req_i(mute_l), .right_mute_req_i(mute_r),
    .left_smp_o(out_l), .right_smp_o(out_r), .smp_vld_o(vld),
    .left_silent_o(sil_l), .right_silent_o(sil_r));

  int total = 0, bad = 0;
  int g_l = GMAX, g_r = GMAX, phase = 0;
  logic signed [SW-1:0] exp_l = '0, exp_r = '0;
  bit exp_vld = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<190000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic signed [SW-1:0] ref_scale(input logic signed [SW-1:0] s, input int g);
    longint p, q;
    if (g == GMAX) return s;
    p = longint'(s) * g;
    q = p / 1024;
    if (p < 0 && (p % 1024) != 0) q = q - 1;
    return q[SW-1:0];
  endfunction

  function automatic int ref_step(input int g, input bit down);
    if (down) return (g > 0) ? g - 1 : 0;
    return (g < GMAX) ? g + 1 : GMAX;
  endfunction

  function automatic logic signed [SW-1:0] pick(input int k);
    case (k % 7)
      0: return POS_FS;
      1: return NEG_FS;
      2: return -25'sd1;
      3: return '0;
      default: return SW'($urandom);
    endcase
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input bit s, input logic signed [SW-1:0] l, input logic signed [SW-1:0] r,
                      input bit ml, input bit mr, input string tag);
    bit st;
    @(negedge clk);
    stb = s; in_l = l; in_r = r; mute_l = ml; mute_r = mr;
    @(posedge clk);
    if (s) begin
      exp_l = ref_scale(l, g_l);
      exp_r = ref_scale(r, g_r);
      st = (phase == DIV - 1);
      phase = st ? 0 : phase + 1;
      if (st) begin
        g_l = ref_step(g_l, ml);
        g_r = ref_step(g_r, mr);
      end
    end
    exp_vld = s;
    #5;
    chk({tag, " left out R7"}, out_l, exp_l);
    chk({tag, " right out R7"}, out_r, exp_r);
    chk({tag, " valid R10"}, vld, exp_vld);
    chk({tag, " left silent R9"}, sil_l, g_l == 0);
    chk({tag, " right silent R9"}, sil_r, g_r == 0);
  endtask

  task automatic hold_reset(input int n);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R5 immediate left zero", out_l, 0);
    chk("R5 immediate right zero", out_r, 0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      stb = 1'b1; mute_l = 1'b1; mute_r = 1'b1; in_l = POS_FS; in_r = NEG_FS;
      @(posedge clk); #5;
      chk("R5 left zero", out_l, 0);
      chk("R5 right zero", out_r, 0);
      chk("R5 left silent", sil_l, 1);
      chk("R5 right silent", sil_r, 1);
      chk("R5 valid low", vld, 0);
    end
    g_l = GMAX; g_r = GMAX; phase = 0; exp_l = '0; exp_r = '0;
    @(negedge clk);
    stb = 1'b0;
    rst_n = 1'b1;
  endtask

  initial begin
    int cnt;
    bit seen;
    logic signed [SW-1:0] v;
    hold_reset(3);

    // R6: first sample after release passes at unity although mute is high
    tick(1, 25'sd100000, -25'sd77777, 1, 0, "R6");
    chk("R6 first left sample unity", out_l, 100000);
    cnt = 1; seen = 0;
    // R2 / R1 / R4: left ramps down, right stays at unity
    for (int i = 1; i < 2100; i++) begin
      v = pick(i);
      tick(1, pick(i + 3), v, 1, 0, "R2");
      chk("R1 right unaffected", out_r, v);
      if (!seen) begin
        cnt++;
        if (sil_l) seen = 1;
      end
    end
    chk("R4 strobes to silence", cnt, 2046);
    // R10: muted channel keeps accepting samples
    for (int i = 0; i < 8; i++) begin
      tick(1, pick(i), pick(i + 1), 1, 0, "R10");
      chk("R10 muted left zero", out_l, 0);
      chk("R10 valid pulses", vld, 1);
    end
    // R11: no strobe holds everything
    v = out_r;
    for (int i = 0; i < 6; i++) begin
      tick(0, POS_FS, NEG_FS, 0, 1, "R11");
      chk("R11 right held", out_r, v);
    end
    // R3 then R8: unmute with full-scale input, reverse mid-ramp
    for (int i = 0; i < 300; i++) tick(1, POS_FS, pick(i), 0, 0, "R3");
    for (int i = 0; i < 120; i++) tick(1, POS_FS, pick(i), 1, 0, "R8");
    for (int i = 0; i < 2200; i++) tick(1, POS_FS, pick(i), 0, 0, "R3");
    chk("R3 left back to unity", out_l, POS_FS);
    chk("R3 left not silent", sil_l, 0);
    // R1: right channel mutes while left stays at unity
    for (int i = 0; i < 900; i++) begin
      v = pick(i + 2);
      tick(1, v, NEG_FS, 0, 1, "R1");
      chk("R1 left unaffected", out_l, v);
    end
    // R11 / R7: irregular strobes, both channels reversing
    for (int i = 0; i < 700; i++)
      tick(1'($urandom), pick(i), pick(i + 5), i[7], !i[6], "R11");
    // R5 / R6: reset in mid-ramp
    for (int i = 0; i < 200; i++) tick(1, pick(i), pick(i), 1, 1, "R2");
    hold_reset(2);
    tick(1, NEG_FS, POS_FS, 1, 1, "R6");
    chk("R6 left unity after release", out_l, NEG_FS);
    chk("R6 right unity after release", out_r, POS_FS);
    for (int i = 0; i < 50; i++) tick(1, pick(i), pick(i + 1), 1, 0, "R2");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule